// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside an external SECDED checker on a memory read path. The checker reports each corrected (single-bit) or uncorrectable (multi-bit) error as a one-cycle strobe, together with the physical address of the failing access and the 8-bit syndrome. The block keeps the first error it sees in one 32-bit word that software can read. That word also holds three control bits. Later errors are dropped until software clears the pending error.

From the flags and the control bits the block produces three outputs. One is a level interrupt request for corrected errors. One is a level system-error request for uncorrectable errors. The third is a one-cycle scrub request that tells the write-back path to repair the location of each corrected read.

Software reads the word whenever it likes. To clear the pending error it writes a 1 to both flag bits in the same write.

Top module: `ecc_err_capture_reg`

## Requirements
- R1: After reset the whole register word reads 0, and `nmi_req`, `serr_req` and `scrub_req` are 0.
- R2: Register layout of `reg_rdata`:
  - bit 0 is the corrected-error flag.
  - bit 1 is the uncorrectable-error flag.
  - bit 2 is the interrupt enable.
  - bit 3 is the system-error enable.
  - bits 11:4 are the captured syndrome.
  - bits 30:12 are `err_addr[31:13]` of the captured error.
  - bit 31 is the scrub-disable bit.
- R3: A strobe that arrives while both flags are 0 sets its flag one clock later. In the same clock it loads the address slice and the syndrome of that error.
- R4: While either flag is 1, a later strobe of either kind changes neither flag, the address field nor the syndrome field. Only the first error is kept, and the two flags are never 1 together.
- R5: If both strobes arrive in the same cycle while no error is pending, only the uncorrectable flag is set.
- R6: A write with `reg_wdata[1:0]` = 2'b11 clears both flags one clock later. A write with only one of those two bits at 1, or with both at 0, leaves both flags unchanged.
- R7: Bits 31, 3 and 2 take the written value on every write. Writes to bits 30:4 have no effect.
- R8: `nmi_req` is 1 exactly when, one cycle earlier, both bit 0 and bit 2 were 1. It is a level and stays high as long as both bits stay set.
- R9: `serr_req` is 1 exactly when, one cycle earlier, both bit 1 and bit 3 were 1.
- R10: A corrected-error strobe without an uncorrectable strobe in the same cycle raises `scrub_req` for one cycle, one clock later, when bit 31 is 0. This happens whether or not the error was captured. When bit 31 is 1, `scrub_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_stb | input | 1 | Corrected-error strobe from the checker |
| mbe_stb | input | 1 | Uncorrectable-error strobe from the checker |
| err_addr | input | 32 | Physical address of the failing access |
| err_syn | input | 8 | ECC syndrome of the failing access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register word |
| nmi_req | output | 1 | Corrected-error interrupt request (level) |
| serr_req | output | 1 | Uncorrectable-error system-error request (level) |
| scrub_req | output | 1 | One-cycle write-back scrub request |

## Verification
A capture gate that stays open after the first error shows up on the next strobe. The address or syndrome field of `reg_rdata` changes one cycle later, or the second flag appears next to the first. A clear that acts on a single written 1 shows up in the very next read: the flag drops when it should have stayed. Wrong enable or flag state reaches `nmi_req` or `serr_req` within two cycles of the strobe or the write. A wrong priority between the strobes shows as the wrong flag bit one cycle after a strobe pair.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  // Fixed low positions of the register word; upper fields follow from sizes
  localparam int unsigned SBE_POS     = 0;
  localparam int unsigned MBE_POS     = 1;
  localparam int unsigned NMI_EN_POS  = 2;
  localparam int unsigned SERR_EN_POS = 3;
  localparam int unsigned SYN_LSB     = 4;

  typedef struct packed {
    logic scrub_dis;
    logic serr_en;
    logic nmi_en;
  } ecc_ctrl_t;

endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  ecc_ctrl_t wr_ctrl,
  output ecc_ctrl_t ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl <= wr_ctrl;
    end
  end

  // R7
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned KEEP_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_stb,
  input  logic              mbe_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              clr,
  output logic              sbe_q,
  output logic              mbe_q,
  output logic [KEEP_W-1:0] addr_q,
  output logic [SYN_W-1:0]  syn_q
);

  localparam int unsigned DROP_W = ADDR_W - KEEP_W;

  logic pending;
  logic take;
  logic unused_addr_low;

  assign pending = sbe_q | mbe_q;
  assign take    = !pending && (sbe_stb || mbe_stb);
  assign unused_addr_low = ^err_addr[DROP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
      addr_q <= '0;
      syn_q  <= '0;
    end else if (take) begin
      mbe_q  <= mbe_stb;
      sbe_q  <= sbe_stb && !mbe_stb;
      addr_q <= err_addr[ADDR_W-1:DROP_W];
      syn_q  <= err_syn;
    end else if (clr) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end
  end

  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sbe_q && mbe_q));

  // R4
  first_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (sbe_q || mbe_q) |=> $stable(addr_q) && $stable(syn_q));

  // R5
  mbe_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (!sbe_q && !mbe_q && sbe_stb && mbe_stb) |=> (mbe_q && !sbe_q));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((sbe_q || mbe_q) && clr) |=> (!sbe_q && !mbe_q));

endmodule

// File: rtl/ecc_cap_out.sv
module ecc_cap_out
  import ecc_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sbe_q,
  input  logic      mbe_q,
  input  ecc_ctrl_t ctrl,
  input  logic      sbe_stb,
  input  logic      mbe_stb,
  output logic      nmi_req,
  output logic      serr_req,
  output logic      scrub_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req   <= 1'b0;
      serr_req  <= 1'b0;
      scrub_req <= 1'b0;
    end else begin
      nmi_req   <= sbe_q && ctrl.nmi_en;
      serr_req  <= mbe_q && ctrl.serr_en;
      scrub_req <= sbe_stb && !mbe_stb && !ctrl.scrub_dis;
    end
  end

  // R10
  scrub_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scrub_req |-> $past(sbe_stb) && !$past(ctrl.scrub_dis));

endmodule

// File: rtl/ecc_err_capture_reg.sv
module ecc_err_capture_reg
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned KEEP_W = 19,
  localparam int unsigned REG_W = KEEP_W + SYN_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_stb,
  input  logic              mbe_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              nmi_req,
  output logic              serr_req,
  output logic              scrub_req
);

  localparam int unsigned ADDR_LSB = SYN_LSB + SYN_W;
  localparam int unsigned DIS_POS  = ADDR_LSB + KEEP_W;

  ecc_ctrl_t         ctrl;
  ecc_ctrl_t         wr_ctrl;
  logic              clr;
  logic              sbe_q;
  logic              mbe_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;
  logic              unused_ro_bits;

  assign wr_ctrl.scrub_dis = reg_wdata[DIS_POS];
  assign wr_ctrl.serr_en   = reg_wdata[SERR_EN_POS];
  assign wr_ctrl.nmi_en    = reg_wdata[NMI_EN_POS];
  assign clr = reg_wr_en && reg_wdata[SBE_POS] && reg_wdata[MBE_POS];
  assign unused_ro_bits = ^reg_wdata[DIS_POS-1:SYN_LSB];

  ecc_cap_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_ctrl (wr_ctrl),
    .ctrl    (ctrl)
  );

  ecc_cap_log #(
    .ADDR_W (ADDR_W),
    .SYN_W  (SYN_W),
    .KEEP_W (KEEP_W)
  ) u_log (
    .clk      (clk),
    .rst      (rst),
    .sbe_stb  (sbe_stb),
    .mbe_stb  (mbe_stb),
    .err_addr (err_addr),
    .err_syn  (err_syn),
    .clr      (clr),
    .sbe_q    (sbe_q),
    .mbe_q    (mbe_q),
    .addr_q   (addr_q),
    .syn_q    (syn_q)
  );

  ecc_cap_out u_out (
    .clk       (clk),
    .rst       (rst),
    .sbe_q     (sbe_q),
    .mbe_q     (mbe_q),
    .ctrl      (ctrl),
    .sbe_stb   (sbe_stb),
    .mbe_stb   (mbe_stb),
    .nmi_req   (nmi_req),
    .serr_req  (serr_req),
    .scrub_req (scrub_req)
  );

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[SBE_POS]               = sbe_q;
    reg_rdata[MBE_POS]               = mbe_q;
    reg_rdata[NMI_EN_POS]            = ctrl.nmi_en;
    reg_rdata[SERR_EN_POS]           = ctrl.serr_en;
    reg_rdata[ADDR_LSB-1:SYN_LSB]    = syn_q;
    reg_rdata[DIS_POS-1:ADDR_LSB]    = addr_q;
    reg_rdata[DIS_POS]               = ctrl.scrub_dis;
  end

  // R8
  nmi_level_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> $past(reg_rdata[SBE_POS]) && $past(reg_rdata[NMI_EN_POS]));

  // R9
  serr_level_chk: assert property (@(posedge clk) disable iff (rst)
    serr_req |-> $past(reg_rdata[MBE_POS]) && $past(reg_rdata[SERR_EN_POS]));

  // R6
  partial_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && (reg_wdata[SBE_POS] != reg_wdata[MBE_POS]) && reg_rdata[SBE_POS])
      |=> reg_rdata[SBE_POS]);

endmodule

// File: tb/tb_ecc_err_capture_reg.sv
module tb_ecc_err_capture_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic        sbe_stb;
  logic        mbe_stb;
  logic [31:0] err_addr;
  logic [7:0]  err_syn;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        nmi_req;
  logic        serr_req;
  logic        scrub_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ecc_err_capture_reg dut (
    .clk       (clk),
    .rst       (rst),
    .sbe_stb   (sbe_stb),
    .mbe_stb   (mbe_stb),
    .err_addr  (err_addr),
    .err_syn   (err_syn),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .nmi_req   (nmi_req),
    .serr_req  (serr_req),
    .scrub_req (scrub_req)
  );

  function automatic logic [31:0] word(input bit dis, input logic [31:0] a,
                                       input logic [7:0] s, input bit se,
                                       input bit ne, input bit m, input bit sb);
    return {dis, a[31:13], s, se, ne, m, sb};
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input bit s, input bit m, input logic [31:0] a, input logic [7:0] y);
    sbe_stb = s; mbe_stb = m; err_addr = a; err_syn = y;
    tick(1);
    sbe_stb = 0; mbe_stb = 0;
  endtask

  task automatic write(input logic [31:0] d);
    reg_wr_en = 1; reg_wdata = d;
    tick(1);
    reg_wr_en = 0; reg_wdata = '0;
  endtask

  task automatic do_reset;
    rst = 1; tick(2); rst = 0; tick(1);
  endtask

  task automatic t_reset;
    do_reset();
    // R1
    chk32("R1 word", reg_rdata, 32'h0);
    chk1("R1 nmi", nmi_req, 0);
    chk1("R1 serr", serr_req, 0);
    chk1("R1 scrub", scrub_req, 0);
  endtask

  task automatic t_first_capture;
    do_reset();
    strobe(1, 0, 32'hDEAD_BEEF, 8'h5A);
    // R3 R2: capture one clock after the strobe
    chk32("R3 sbe capture", reg_rdata, word(0, 32'hDEAD_BEEF, 8'h5A, 0, 0, 0, 1));
    strobe(0, 1, 32'h1234_5678, 8'hC3);
    strobe(1, 0, 32'h0F0F_0F0F, 8'h11);
    // R4
    chk32("R4 later errors dropped", reg_rdata, word(0, 32'hDEAD_BEEF, 8'h5A, 0, 0, 0, 1));
  endtask

  task automatic t_mbe_first;
    do_reset();
    strobe(0, 1, 32'hA5A5_0000, 8'h81);
    // R3
    chk32("R3 mbe capture", reg_rdata, word(0, 32'hA5A5_0000, 8'h81, 0, 0, 1, 0));
    strobe(1, 0, 32'hFFFF_FFFF, 8'hFF);
    // R4
    chk32("R4 sbe after mbe dropped", reg_rdata, word(0, 32'hA5A5_0000, 8'h81, 0, 0, 1, 0));
  endtask

  task automatic t_clear;
    do_reset();
    strobe(1, 0, 32'h8000_2000, 8'h07);
    write(32'h0000_0001);
    // R6
    chk1("R6 single 1 no clear sbe", reg_rdata[0], 1);
    write(32'h0000_0002);
    chk1("R6 other single 1 no clear", reg_rdata[0], 1);
    write(32'h0000_0000);
    chk1("R6 zero write no clear", reg_rdata[0], 1);
    write(32'h0000_0003);
    chk32("R6 both cleared", reg_rdata & 32'h3, 32'h0);
    strobe(0, 1, 32'h4000_6000, 8'h3C);
    // R3 capture works again after clear
    chk32("R3 capture after clear", reg_rdata, word(0, 32'h4000_6000, 8'h3C, 0, 0, 1, 0));
  endtask

  task automatic t_both;
    do_reset();
    strobe(1, 1, 32'h2468_ACE0, 8'h99);
    // R5
    chk32("R5 mbe priority", reg_rdata, word(0, 32'h2468_ACE0, 8'h99, 0, 0, 1, 0));
  endtask

  task automatic t_rw_bits;
    do_reset();
    write(32'hFFFF_FFFC);
    // R7
    chk32("R7 ro bits ignored", reg_rdata, 32'h8000_000C);
    write(32'h0000_0000);
    chk32("R7 rw bits cleared", reg_rdata, 32'h0);
  endtask

  task automatic t_irq;
    do_reset();
    write(32'h0000_0004);
    strobe(1, 0, 32'h0, 8'h01);
    tick(1);
    // R8
    chk1("R8 nmi raised", nmi_req, 1);
    chk1("R9 serr quiet on sbe", serr_req, 0);
    tick(3);
    chk1("R8 nmi level held", nmi_req, 1);
    write(32'h0000_0007);
    tick(1);
    chk1("R8 nmi drops after clear", nmi_req, 0);
    do_reset();
    strobe(0, 1, 32'h0, 8'h02);
    tick(1);
    chk1("R9 serr needs enable", serr_req, 0);
    write(32'h0000_0008);
    tick(1);
    // R9
    chk1("R9 serr raised", serr_req, 1);
    chk1("R8 nmi quiet on mbe", nmi_req, 0);
  endtask

  task automatic t_scrub;
    do_reset();
    strobe(1, 0, 32'h0, 8'h01);
    // R10
    chk1("R10 scrub pulse", scrub_req, 1);
    tick(1);
    chk1("R10 scrub one cycle", scrub_req, 0);
    strobe(1, 0, 32'h0, 8'h02);
    chk1("R10 scrub while pending", scrub_req, 1);
    strobe(1, 1, 32'h0, 8'h03);
    chk1("R10 no scrub with mbe", scrub_req, 0);
    write(32'h8000_0003);
    strobe(1, 0, 32'h0, 8'h04);
    chk1("R10 scrub disabled", scrub_req, 0);
  endtask

  initial begin
    rst = 1; sbe_stb = 0; mbe_stb = 0; err_addr = '0; err_syn = '0;
    reg_wr_en = 0; reg_wdata = '0;
    t_reset();
    t_first_capture();
    t_mbe_first();
    t_clear();
    t_both();
    t_rw_bits();
    t_irq();
    t_scrub();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule